// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Programmable Pin

The block gathers single-cycle event strobes from the surrounding device controller into sticky status bits, masks them with per-bit enables and drives one interrupt request pin. The sources are bus reset, start-of-frame, pseudo start-of-frame, suspend, resume, a high-speed status flag and one receive and one transmit bit per endpoint. Six DMA reason sources sit one level below. They latch in their own sticky register, are masked by their own enables and then merge into one summary bit of the main status vector.

Endpoint events come with a 2-bit handshake code. A filter setting for the IN direction (transmit bits) and one for the OUT direction (receive bits) decide which handshakes raise the bit. One setting passes only the first NAK after the last ACK or NYET on that pipe. The pin has a programmable active level and a global enable. It signals either as a level that follows the masked status or as a fixed-length pulse for each newly latched enabled event.

All interfaces are plain control and status pins. There is no data stream, so no valid/ready handshake and no back-pressure. Enables and configuration come from a register file outside the block. Clear strobes carry the write-one-to-clear data from that file.

Top module: `irq_aggregator`

## Requirements
- R1: Main status bit positions are: 0 bus reset, 1 SOF, 2 pseudo SOF, 3 suspend, 4 resume, 5 high-speed status, 6 DMA summary, 7+2i endpoint i receive, 8+2i endpoint i transmit. A strobe sampled at a rising edge makes its bit read 1 after that edge. The bit stays 1 until it is cleared.
- R2: A 1 on a clear input bit clears that status bit at the next edge. If a set arrives in the same cycle as the clear, the set wins and the bit stays 1.
- R3: Each DMA reason bit latches its strobe and clears on its own clear input, with set winning. Status bit 6 reads as the OR of all DMA reason bits ANDed with their DMA enables.
- R4: In level mode (pin_pulse=0) with glb_en=1, irq_pin equals pin_pol while any status bit is 1 and enabled. Otherwise irq_pin equals the inverse of pin_pol.
- R5: In pulse mode (pin_pulse=1) with glb_en=1, irq_pin is active (equal to pin_pol) for exactly PULSE_LEN cycles after each edge at which an enabled status bit goes from 0 to 1. A new such event restarts the count. Re-setting a bit that already reads 1 starts no pulse.
- R6: With glb_en=0, irq_pin is held at the inverse of pin_pol, while status bits keep latching.
- R7: Handshake codes are 0 ACK, 1 NYET, 2 NAK, 3 none. Filter value 0 passes ACK, NYET and NAK. Filters 1 and 3 pass ACK and NYET only. Filter 2 passes ACK and NYET, and a NAK only when no NAK has been seen on that pipe since reset or its last ACK/NYET. Every NAK marks the pipe, whatever the filter, and every ACK or NYET unmarks it. The in_filter input governs the transmit bits and out_filter the receive bits.
- R8: Status bit 5 sets when hs_active is sampled 1 after being sampled 0 (or after reset). A fall of hs_active does not set it.
- R9: A clear applied to status bit 6 has no effect; the summary bit changes only with the DMA reason bits and enables.
- R10: After reset all status and DMA reason bits are 0, no pulse is pending, all pipes are unmarked, and irq_pin equals the inverse of pin_pol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_bus_reset | input | 1 | Bus reset strobe |
| evt_sof | input | 1 | Start-of-frame strobe |
| evt_psof | input | 1 | Pseudo start-of-frame strobe |
| evt_suspend | input | 1 | Suspend strobe |
| evt_resume | input | 1 | Resume strobe |
| hs_active | input | 1 | Level: link is running at high speed |
| ep_rx_evt | input | NUM_EP | Per-endpoint receive handshake strobe |
| ep_rx_code | input | 2*NUM_EP | Receive handshake codes, endpoint i at [2i+1:2i] |
| ep_tx_evt | input | NUM_EP | Per-endpoint transmit handshake strobe |
| ep_tx_code | input | 2*NUM_EP | Transmit handshake codes, endpoint i at [2i+1:2i] |
| in_filter | input | 2 | Handshake filter for transmit (IN) bits |
| out_filter | input | 2 | Handshake filter for receive (OUT) bits |
| dma_evt | input | 6 | DMA reason strobes |
| dma_en | input | 6 | DMA reason enables |
| dma_clr | input | 6 | DMA reason clear strobes |
| main_en | input | 7+2*NUM_EP | Main status enables |
| main_clr | input | 7+2*NUM_EP | Main status clear strobes |
| glb_en | input | 1 | Global pin enable |
| pin_pol | input | 1 | Active level of irq_pin |
| pin_pulse | input | 1 | 1 pulse signalling, 0 level signalling |
| irq_status | output | 7+2*NUM_EP | Main status vector |
| dma_reason | output | 6 | DMA reason vector |
| irq_pin | output | 1 | Interrupt request pin |

## Verification
A sticky bit that drops or is missed shows on irq_status at the sample right after the edge that should have changed it. With the bit enabled in level mode, irq_pin shows the same error in the same cycle. A wrong first-NAK mark on a pipe shows on the next NAK for that pipe, as a bit that sets or fails to set. A pulse counter that is off by one shows at the end of the pulse, within PULSE_LEN cycles of the triggering event. The bench mixes directed sequences for each of these cases with long random runs, and compares every output every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    HS_ACK  = 2'd0,
    HS_NYET = 2'd1,
    HS_NAK  = 2'd2,
    HS_NONE = 2'd3
  } hs_code_e;

  typedef enum logic [1:0] {
    FLT_ALL       = 2'd0,
    FLT_NO_NAK    = 2'd1,
    FLT_FIRST_NAK = 2'd2,
    FLT_RSVD      = 2'd3
  } flt_e;

  localparam int BIT_BRST   = 0;
  localparam int BIT_SOF    = 1;
  localparam int BIT_PSOF   = 2;
  localparam int BIT_SUSP   = 3;
  localparam int BIT_RESUME = 4;
  localparam int BIT_HS     = 5;
  localparam int BIT_DMA    = 6;
  localparam int BIT_EP0    = 7;
  localparam int DMA_SRC    = 6;

  function automatic int rx_bit(input int ep);
    return BIT_EP0 + 2 * ep;
  endfunction

  function automatic int tx_bit(input int ep);
    return BIT_EP0 + 2 * ep + 1;
  endfunction
endpackage

// File: rtl/irq_hs_qual.sv
module irq_hs_qual
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic [1:0] code,
  input  logic [1:0] mode,
  output logic       hit
);
  logic nak_seen_q;
  logic is_ack, is_nak;

  always_comb begin
    is_ack = (code == HS_ACK) || (code == HS_NYET);
    is_nak = (code == HS_NAK);
    hit = 1'b0;
    if (evt) begin
      if (is_ack) hit = 1'b1;
      else if (is_nak) begin
        case (mode)
          FLT_ALL:       hit = 1'b1;
          FLT_FIRST_NAK: hit = !nak_seen_q;
          default:       hit = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nak_seen_q <= 1'b0;
    else if (evt && is_ack) nak_seen_q <= 1'b0;
    else if (evt && is_nak) nak_seen_q <= 1'b1;
  end

  // R7: filters 1 and 3 never pass a NAK
  a_r7_nak_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && code == HS_NAK && mode[0]) |-> !hit);

  // R7: two NAKs in a row under first-NAK filter pass at most once
  a_r7_first_nak_once: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && code == HS_NAK && mode == FLT_FIRST_NAK)
    |=> !(evt && code == HS_NAK && hit && mode == FLT_FIRST_NAK));
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  // R2: a set always lands, even against a clear
  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(set)) == $past(set)));

  // R1: set bits without a clear stay set
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(q & ~clr)) == $past(q & ~clr)));
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int N         = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] eff_q,
  input  logic [N-1:0] eff_nx,
  input  logic [N-1:0] en,
  input  logic         glb_en,
  input  logic         pol,
  input  logic         pulse_mode,
  output logic         pin
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;
  logic          new_hit;
  logic          active;

  assign new_hit = |(eff_nx & ~eff_q & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (new_hit)       cnt_q <= CNT_MAX;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    if (pulse_mode) active = (cnt_q != '0);
    else            active = |(eff_q & en);
    pin = (glb_en && active) ? pol : !pol;
  end

  // R5: counter never exceeds the pulse length
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R5: a new enabled event restarts the full pulse
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    new_hit |=> cnt_q == CNT_MAX);

  // R6: globally disabled pin rests inactive
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> pin == !pol);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter  int NUM_EP    = 8,
  parameter  int PULSE_LEN = 4,
  localparam int W         = BIT_EP0 + 2 * NUM_EP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_bus_reset,
  input  logic                  evt_sof,
  input  logic                  evt_psof,
  input  logic                  evt_suspend,
  input  logic                  evt_resume,
  input  logic                  hs_active,
  input  logic [NUM_EP-1:0]     ep_rx_evt,
  input  logic [2*NUM_EP-1:0]   ep_rx_code,
  input  logic [NUM_EP-1:0]     ep_tx_evt,
  input  logic [2*NUM_EP-1:0]   ep_tx_code,
  input  logic [1:0]            in_filter,
  input  logic [1:0]            out_filter,
  input  logic [DMA_SRC-1:0]    dma_evt,
  input  logic [DMA_SRC-1:0]    dma_en,
  input  logic [DMA_SRC-1:0]    dma_clr,
  input  logic [W-1:0]          main_en,
  input  logic [W-1:0]          main_clr,
  input  logic                  glb_en,
  input  logic                  pin_pol,
  input  logic                  pin_pulse,
  output logic [W-1:0]          irq_status,
  output logic [DMA_SRC-1:0]    dma_reason,
  output logic                  irq_pin
);
  logic              hs_q;
  logic [NUM_EP-1:0] rx_hit, tx_hit;
  logic [W-1:0]      main_set, main_q, main_nx;
  logic [W-1:0]      eff_q, eff_nx;
  logic [DMA_SRC-1:0] reason_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 1'b0;
    else        hs_q <= hs_active;
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    irq_hs_qual u_rx (
      .clk(clk), .rst_n(rst_n), .evt(ep_rx_evt[g]),
      .code(ep_rx_code[2*g +: 2]), .mode(out_filter), .hit(rx_hit[g]));
    irq_hs_qual u_tx (
      .clk(clk), .rst_n(rst_n), .evt(ep_tx_evt[g]),
      .code(ep_tx_code[2*g +: 2]), .mode(in_filter), .hit(tx_hit[g]));
  end

  always_comb begin
    main_set             = '0;
    main_set[BIT_BRST]   = evt_bus_reset;
    main_set[BIT_SOF]    = evt_sof;
    main_set[BIT_PSOF]   = evt_psof;
    main_set[BIT_SUSP]   = evt_suspend;
    main_set[BIT_RESUME] = evt_resume;
    main_set[BIT_HS]     = hs_active && !hs_q;
    for (int i = 0; i < NUM_EP; i++) begin
      main_set[rx_bit(i)] = rx_hit[i];
      main_set[tx_bit(i)] = tx_hit[i];
    end
  end

  irq_sticky_bank #(.N(W)) u_main (
    .clk(clk), .rst_n(rst_n), .set(main_set), .clr(main_clr), .q(main_q));

  irq_sticky_bank #(.N(DMA_SRC)) u_dma (
    .clk(clk), .rst_n(rst_n), .set(dma_evt), .clr(dma_clr), .q(dma_reason));

  always_comb begin
    main_nx   = (main_q & ~main_clr) | main_set;
    reason_nx = (dma_reason & ~dma_clr) | dma_evt;
    eff_q           = main_q;
    eff_q[BIT_DMA]  = |(dma_reason & dma_en);
    eff_nx          = main_nx;
    eff_nx[BIT_DMA] = |(reason_nx & dma_en);
  end

  assign irq_status = eff_q;

  irq_pin_drv #(.N(W), .PULSE_LEN(PULSE_LEN)) u_pin (
    .clk(clk), .rst_n(rst_n), .eff_q(eff_q), .eff_nx(eff_nx), .en(main_en),
    .glb_en(glb_en), .pol(pin_pol), .pulse_mode(pin_pulse), .pin(irq_pin));

  // R8: high-speed bit only rises after hs_active was sampled high
  a_r8_hs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[BIT_HS]) |-> $past(hs_active));

  // R9: clearing the summary bit alone leaves it unchanged
  a_r9_summary_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (main_clr[BIT_DMA] && dma_clr == '0 && dma_evt == '0) |=>
      (irq_status[BIT_DMA] || !$past(irq_status[BIT_DMA]) || $past(dma_en) != dma_en));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int NEP  = 8;
  localparam int PLEN = 4;
  localparam int W    = 7 + 2 * NEP;
  localparam int ND   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_bus_reset, evt_sof, evt_psof, evt_suspend, evt_resume, hs_active;
  logic [NEP-1:0]   ep_rx_evt, ep_tx_evt;
  logic [2*NEP-1:0] ep_rx_code, ep_tx_code;
  logic [1:0] in_filter, out_filter;
  logic [ND-1:0] dma_evt, dma_en, dma_clr;
  logic [W-1:0] main_en, main_clr;
  logic glb_en, pin_pol, pin_pulse;
  logic [W-1:0] irq_status;
  logic [ND-1:0] dma_reason;
  logic irq_pin;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator #(.NUM_EP(NEP), .PULSE_LEN(PLEN)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_bus_reset(evt_bus_reset), .evt_sof(evt_sof),
    .evt_psof(evt_psof), .evt_suspend(evt_suspend), .evt_resume(evt_resume),
    .hs_active(hs_active), .ep_rx_evt(ep_rx_evt), .ep_rx_code(ep_rx_code),
    .ep_tx_evt(ep_tx_evt), .ep_tx_code(ep_tx_code), .in_filter(in_filter),
    .out_filter(out_filter), .dma_evt(dma_evt), .dma_en(dma_en), .dma_clr(dma_clr),
    .main_en(main_en), .main_clr(main_clr), .glb_en(glb_en), .pin_pol(pin_pol),
    .pin_pulse(pin_pulse), .irq_status(irq_status), .dma_reason(dma_reason),
    .irq_pin(irq_pin));

  // reference model state, built from the requirements
  logic [W-1:0]   m_st;
  logic [ND-1:0]  m_rs;
  logic [NEP-1:0] m_nak_rx, m_nak_tx;
  logic           m_hsq;
  int             m_cnt;

  function automatic logic pass_f(input logic ev, input logic [1:0] code,
                                  input logic [1:0] flt, input logic marked);
    if (!ev) return 1'b0;
    if (code == 2'd0 || code == 2'd1) return 1'b1;
    if (code == 2'd2) return (flt == 2'd0) || (flt == 2'd2 && !marked);
    return 1'b0;
  endfunction

  function automatic logic mark_f(input logic ev, input logic [1:0] code,
                                  input logic marked);
    if (!ev) return marked;
    if (code == 2'd0 || code == 2'd1) return 1'b0;
    if (code == 2'd2) return 1'b1;
    return marked;
  endfunction

  function automatic logic [W-1:0] eff_f(input logic [W-1:0] st,
                                         input logic [ND-1:0] rs,
                                         input logic [ND-1:0] en);
    logic [W-1:0] e;
    e = st;
    e[6] = |(rs & en);
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= '0; m_rs <= '0; m_nak_rx <= '0; m_nak_tx <= '0;
      m_hsq <= 1'b0; m_cnt <= 0;
    end else begin
      logic [W-1:0] set, st_n;
      logic [ND-1:0] rs_n;
      set = '0;
      set[0] = evt_bus_reset; set[1] = evt_sof; set[2] = evt_psof;
      set[3] = evt_suspend;   set[4] = evt_resume;
      set[5] = hs_active && !m_hsq;
      for (int i = 0; i < NEP; i++) begin
        set[7+2*i] = pass_f(ep_rx_evt[i], ep_rx_code[2*i +: 2], out_filter, m_nak_rx[i]);
        set[8+2*i] = pass_f(ep_tx_evt[i], ep_tx_code[2*i +: 2], in_filter, m_nak_tx[i]);
        m_nak_rx[i] <= mark_f(ep_rx_evt[i], ep_rx_code[2*i +: 2], m_nak_rx[i]);
        m_nak_tx[i] <= mark_f(ep_tx_evt[i], ep_tx_code[2*i +: 2], m_nak_tx[i]);
      end
      st_n = (m_st & ~main_clr) | set;
      st_n[6] = 1'b0;
      rs_n = (m_rs & ~dma_clr) | dma_evt;
      if (|(eff_f(st_n, rs_n, dma_en) & ~eff_f(m_st, m_rs, dma_en) & main_en))
        m_cnt <= PLEN;
      else if (m_cnt > 0)
        m_cnt <= m_cnt - 1;
      m_st <= st_n; m_rs <= rs_n; m_hsq <= hs_active;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] e;
    logic act;
    e = eff_f(m_st, m_rs, dma_en);
    chk("R1 fixed sources", 32'(irq_status[4:0]), 32'(e[4:0]));
    chk("R8 hs bit", 32'(irq_status[5]), 32'(e[5]));
    chk("R3 dma summary", 32'(irq_status[6]), 32'(e[6]));
    chk("R7 endpoint bits", 32'(irq_status[W-1:7]), 32'(e[W-1:7]));
    chk("R3 dma reasons", 32'(dma_reason), 32'(m_rs));
    act = pin_pulse ? (m_cnt > 0) : |(e & main_en);
    if (!glb_en)        chk("R6 pin gated", 32'(irq_pin), 32'(!pin_pol));
    else if (pin_pulse) chk("R5 pulse pin", 32'(irq_pin), 32'(act ? pin_pol : !pin_pol));
    else                chk("R4 level pin", 32'(irq_pin), 32'(act ? pin_pol : !pin_pol));
  endtask

  task automatic quiet();
    evt_bus_reset = 0; evt_sof = 0; evt_psof = 0; evt_suspend = 0; evt_resume = 0;
    ep_rx_evt = '0; ep_tx_evt = '0; ep_rx_code = '1; ep_tx_code = '1;
    dma_evt = '0; dma_clr = '0; main_clr = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compare_all();
    quiet();
  endtask

  initial begin
    void'($urandom(32'd90210));
    quiet();
    hs_active = 0; in_filter = 0; out_filter = 0;
    dma_en = '1; main_en = '1; glb_en = 1; pin_pol = 0; pin_pulse = 0;
    repeat (3) @(negedge clk);
    // R10: reset state, pin at inverse polarity
    chk("R10 reset status", 32'(irq_status), 32'd0);
    chk("R10 reset reasons", 32'(dma_reason), 32'd0);
    chk("R10 reset pin", 32'(irq_pin), 32'd1);
    rst_n = 1;
    step();

    // R1: SOF strobe latches bit 1 and holds
    evt_sof = 1; step();
    chk("R1 sof set", 32'(irq_status[1]), 32'd1);
    step(); step();
    chk("R1 sof held", 32'(irq_status[1]), 32'd1);
    chk("R4 level active low", 32'(irq_pin), 32'd0);

    // R2: clear and set in the same cycle, then a plain clear
    evt_sof = 1; main_clr[1] = 1; step();
    chk("R2 set beats clear", 32'(irq_status[1]), 32'd1);
    main_clr[1] = 1; step();
    chk("R2 cleared", 32'(irq_status[1]), 32'd0);

    // R3, R9: DMA reason into summary; clear on bit 6 ignored
    dma_evt[2] = 1; step();
    chk("R3 summary set", 32'(irq_status[6]), 32'd1);
    main_clr[6] = 1; step();
    chk("R9 summary clear ignored", 32'(irq_status[6]), 32'd1);
    dma_en[2] = 0; step();
    chk("R3 summary masked", 32'(irq_status[6]), 32'd0);
    dma_en[2] = 1; dma_clr[2] = 1; step();
    chk("R3 reason cleared", 32'(dma_reason[2]), 32'd0);

    // R7: first-NAK filter on OUT pipe of endpoint 0 (bit 7)
    out_filter = 2'd2;
    ep_rx_evt[0] = 1; ep_rx_code[1:0] = 2'd2; step();
    chk("R7 first nak passes", 32'(irq_status[7]), 32'd1);
    main_clr[7] = 1; step();
    ep_rx_evt[0] = 1; ep_rx_code[1:0] = 2'd2; step();
    chk("R7 second nak blocked", 32'(irq_status[7]), 32'd0);
    ep_rx_evt[0] = 1; ep_rx_code[1:0] = 2'd1; step();
    chk("R7 nyet passes", 32'(irq_status[7]), 32'd1);
    main_clr[7] = 1; step();
    ep_rx_evt[0] = 1; ep_rx_code[1:0] = 2'd2; step();
    chk("R7 nak rearmed", 32'(irq_status[7]), 32'd1);
    main_clr[7] = 1; in_filter = 2'd1; step();
    ep_tx_evt[3] = 1; ep_tx_code[7:6] = 2'd2; step();
    chk("R7 in filter blocks nak", 32'(irq_status[14]), 32'd0);

    // R8: rise sets, fall does not
    hs_active = 1; step();
    chk("R8 rise sets", 32'(irq_status[5]), 32'd1);
    main_clr[5] = 1; step();
    hs_active = 0; step(); step();
    chk("R8 fall ignored", 32'(irq_status[5]), 32'd0);

    // R5: pulse mode length, then no pulse for an already-set bit
    main_clr = '1; dma_clr = '1; step();
    pin_pulse = 1; pin_pol = 1; step();
    evt_resume = 1; step();
    for (int k = 0; k < PLEN; k++) begin
      chk("R5 pulse active", 32'(irq_pin), 32'd1);
      if (k < PLEN - 1) step();
    end
    step();
    chk("R5 pulse ended", 32'(irq_pin), 32'd0);
    evt_resume = 1; step();
    chk("R5 no pulse on set bit", 32'(irq_pin), 32'd0);

    // R6: global disable
    glb_en = 0; evt_psof = 1; step();
    chk("R6 gated", 32'(irq_pin), 32'd0);
    chk("R6 still latches", 32'(irq_status[2]), 32'd1);
    glb_en = 1;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(99) < 3) begin
        in_filter = 2'($urandom); out_filter = 2'($urandom);
      end
      if ($urandom_range(99) < 2) begin
        glb_en = ($urandom_range(9) != 0); pin_pol = 1'($urandom);
        pin_pulse = 1'($urandom);
        main_en = W'({$urandom, $urandom}); dma_en = ND'($urandom);
      end
      if ($urandom_range(99) < 2) hs_active = ~hs_active;
      evt_bus_reset = ($urandom_range(99) < 5);
      evt_sof       = ($urandom_range(99) < 10);
      evt_psof      = ($urandom_range(99) < 5);
      evt_suspend   = ($urandom_range(99) < 3);
      evt_resume    = ($urandom_range(99) < 3);
      for (int i = 0; i < NEP; i++) begin
        ep_rx_evt[i] = ($urandom_range(99) < 12);
        ep_tx_evt[i] = ($urandom_range(99) < 12);
        ep_rx_code[2*i +: 2] = 2'($urandom);
        ep_tx_code[2*i +: 2] = 2'($urandom);
      end
      for (int i = 0; i < ND; i++) begin
        dma_evt[i] = ($urandom_range(99) < 4);
        dma_clr[i] = ($urandom_range(99) < 10);
      end
      for (int i = 0; i < W; i++) main_clr[i] = ($urandom_range(99) < 10);
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule